// File: doc/BRIEF.md
# I3C Target Private Transfer Engine

This block is the bus-facing half of an I3C target. It handles private transfers that a controller addresses to the target's dynamic address. The SCL and SDA lines are oversampled by the system clock and passed through a synchronizer. From the synchronized levels the block finds Start, Repeated Start and Stop conditions, decodes the 7-bit address and direction header, and answers with ACK or NACK. It then moves 9-bit words in either direction. Received bytes are parked in a single-entry receive slot. Bytes to send are taken from a single-entry transmit slot.

Host logic supplies four settings: the dynamic address, the operating mode, and the maximum write and read lengths agreed with the controller. It pops the receive slot and fills the transmit slot. It watches a vector of sticky event and error flags, which it clears with a write-one-to-clear pulse vector.

On a read, the transition bit does two jobs. The target drives 1 to say more data follows, then lets go of SDA while SCL is high. A controller that wants to stop early pulls SDA low at that moment. The block sees this as an ordinary Repeated Start.

Top module: `i3c_priv_target`

## Requirements
- R1: With `mode_i3c_i` low, a header is neither acknowledged nor decoded: SDA stays released through the ACK slot, no byte reaches the receive slot and no flag is set.
- R2: A header whose 7-bit address (sent MSB first) equals `dyn_addr_i` is acknowledged by driving SDA low during the ninth clock. The same header sets flag bit 0 (address match) and latches its eighth bit on `rnw_o` (0 write, 1 read).
- R3: A header with any other address is not acknowledged. The target then stays silent, delivers nothing and sets no flag until the next Start or Stop.
- R4: In a write, each word is 8 data bits MSB first plus a transition bit. The byte appears on `rx_data_o` with `rx_full_o` set, and stays there until `rx_pop_i`.
- R5: The written transition bit must make the count of ones over the 9 bits odd. Otherwise flag bit 4 is set, and the byte is still delivered.
- R6: The write byte whose number (counting from 1 within the transfer) exceeds `max_wr_len_i` sets flag bit 5.
- R7: In a read, each byte is taken from the transmit slot and driven MSB first. It is followed by a transition bit of 1 when the next byte is already queued and the read limit has not been reached.
- R8: When no next byte is queued, the target drives the transition bit as 0 and releases SDA on the next SCL fall.
- R9: A controller that pulls SDA low while SCL is high during a transition bit of 1 ends the read. This sets flag bit 2 (restart) and flag bit 3 (complete), but not bit 1.
- R10: A Stop ending an acknowledged transfer sets flag bit 1 and bit 3. A Repeated Start ending it sets bit 2 and bit 3.
- R11: A byte arriving while the receive slot is full and not being popped is dropped; the old byte is kept and flag bit 6 is set. A read byte needed while the transmit slot is empty is sent as 8'hFF and sets flag bit 7.
- R12: Once the number of bytes sent in a read reaches `max_rd_len_i`, the transition bit is 0 even if a byte is queued. That byte stays in the slot.
- R13: Flags stay set until the matching bit of `flags_clr_i` is pulsed. `rx_full_o` clears on a pop. `tx_full_o` sets on a push and clears when the byte is loaded for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i3c_i | input | 1 | 1 selects I3C operation, 0 means legacy two-wire mode |
| dyn_addr_i | input | 7 | Dynamic address assigned to this target |
| max_wr_len_i | input | LEN_W | Largest write length in bytes |
| max_rd_len_i | input | LEN_W | Largest read length in bytes |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| sda_oe_o | output | 1 | Target drives SDA when high |
| sda_o | output | 1 | Level driven on SDA |
| rx_data_o | output | 8 | Byte in the receive slot |
| rx_full_o | output | 1 | Receive slot holds a byte |
| rx_pop_i | input | 1 | Host takes the received byte |
| tx_data_i | input | 8 | Byte to queue for sending |
| tx_push_i | input | 1 | Queue `tx_data_i` into an empty transmit slot |
| tx_full_o | output | 1 | Transmit slot holds a byte |
| rnw_o | output | 1 | Direction of the last matched header |
| flags_o | output | 8 | Sticky flags: 0 match, 1 stop, 2 restart, 3 complete, 4 parity, 5 write overflow, 6 receive overrun, 7 transmit underrun |
| flags_clr_i | input | 8 | Write-one-to-clear pulses for `flags_o` |

## Verification
The bench builds the block with `LEN_W` set to 4 and a two-stage synchronizer. The narrow length field lets a two-byte write limit and a one-byte read limit be reached in a few words. The bus is modelled as a wired line with a pull-up, and each bus phase lasts eight clocks. This gives the synchronizer and edge-detect delay enough room to be seen, while keeping the controller-side abort within the window in which the target has released SDA.

// File: rtl/i3ct_pkg.sv
package i3ct_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ACK,
      ST_WR,
      ST_RD,
      ST_RDEND,
      ST_SKIP
   } xfer_st_e;

   localparam int FLAG_N   = 8;
   localparam int FL_MATCH = 0;
   localparam int FL_STOP  = 1;
   localparam int FL_RSTRT = 2;
   localparam int FL_DONE  = 3;
   localparam int FL_PAR   = 4;
   localparam int FL_WOVF  = 5;
   localparam int FL_RXOV  = 6;
   localparam int FL_TXUN  = 7;

   localparam logic [7:0] UNDERRUN_BYTE = 8'hFF;

endpackage

// File: rtl/i3ct_busmon.sv
module i3ct_busmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_s;
   logic scl_q;
   logic sda_q;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] scl_r;
         logic [SYNC_STAGES-1:0] sda_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= '1;
               sda_r <= '1;
            end else begin
               scl_r[0] <= scl_i;
               sda_r[0] <= sda_i;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  scl_r[k] <= scl_r[k-1];
                  sda_r[k] <= sda_r[k-1];
               end
            end
         end
         assign scl_s = scl_r[SYNC_STAGES-1];
         assign sda_s = sda_r[SYNC_STAGES-1];
      end else begin : g_direct
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i3ct_slot.sv
module i3ct_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdat_i,
   input  logic         rd_i,
   output logic         full_o,
   output logic [W-1:0] data_o
);

   logic accept;

   assign accept = wr_i & (~full_o | rd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         data_o <= '0;
      end else begin
         full_o <= (full_o & ~rd_i) | accept;
         if (accept) data_o <= wdat_i;
      end
   end

endmodule

// File: rtl/i3ct_flags.sv
module i3ct_flags #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_o[i] <= 1'b0;
            else        flags_o[i] <= (flags_o[i] & ~clr_i[i]) | set_i[i];
         end
      end
   endgenerate

endmodule

// File: rtl/i3ct_xfer.sv
module i3ct_xfer
   import i3ct_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              mode_i3c,
   input  logic [6:0]        dyn_addr,
   input  logic [LEN_W-1:0]  max_wr_len,
   input  logic [LEN_W-1:0]  max_rd_len,
   input  logic              rx_full,
   input  logic              rx_pop,
   input  logic              tx_full,
   input  logic [7:0]        tx_data,
   output logic              rx_wr,
   output logic [7:0]        rx_wdat,
   output logic              tx_rd,
   output logic              sda_oe,
   output logic              sda_o,
   output logic              rnw,
   output logic [FLAG_N-1:0] flag_set
);

   localparam int CNT_W = LEN_W + 1;

   xfer_st_e         st, st_n;
   logic [3:0]       bcnt, bcnt_n;
   logic [7:0]       sh, sh_n;
   logic [CNT_W-1:0] wcnt, wcnt_n, rcnt, rcnt_n;
   logic             hit, hit_n, more, more_n;
   logic             oe_n, o_n, rnw_n;
   logic             load;
   logic             active;
   logic             nxt_more;

   assign active   = (st == ST_WR) || (st == ST_RD) || (st == ST_RDEND);
   assign nxt_more = tx_full && (rcnt < {1'b0, max_rd_len});

   always_comb begin
      st_n     = st;
      bcnt_n   = bcnt;
      sh_n     = sh;
      wcnt_n   = wcnt;
      rcnt_n   = rcnt;
      hit_n    = hit;
      more_n   = more;
      oe_n     = sda_oe;
      o_n      = sda_o;
      rnw_n    = rnw;
      flag_set = '0;
      rx_wr    = 1'b0;
      rx_wdat  = sh;
      tx_rd    = 1'b0;
      load     = 1'b0;
      if (start_det) begin
         flag_set[FL_RSTRT] = active;
         flag_set[FL_DONE]  = active;
         st_n   = mode_i3c ? ST_HDR : ST_SKIP;
         bcnt_n = '0;
         wcnt_n = '0;
         rcnt_n = '0;
         oe_n   = 1'b0;
         o_n    = 1'b1;
      end else if (stop_det) begin
         flag_set[FL_STOP] = active;
         flag_set[FL_DONE] = active;
         st_n = ST_IDLE;
         oe_n = 1'b0;
         o_n  = 1'b1;
      end else begin
         case (st)
            ST_HDR: if (scl_rise) begin
               sh_n   = {sh[6:0], sda_s};
               bcnt_n = bcnt + 4'd1;
               if (bcnt == 4'd7) begin
                  st_n   = ST_ACK;
                  bcnt_n = '0;
                  hit_n  = (sh[6:0] == dyn_addr);
                  if (sh[6:0] == dyn_addr) begin
                     rnw_n              = sda_s;
                     flag_set[FL_MATCH] = 1'b1;
                  end
               end
            end
            ST_ACK: if (scl_fall) begin
               if (bcnt == 4'd0) begin
                  bcnt_n = 4'd1;
                  if (!hit) st_n = ST_SKIP;
                  else begin
                     oe_n = 1'b1;
                     o_n  = 1'b0;
                  end
               end else if (rnw) begin
                  load = 1'b1;
                  st_n = ST_RD;
               end else begin
                  bcnt_n = '0;
                  oe_n   = 1'b0;
                  o_n    = 1'b1;
                  st_n   = ST_WR;
               end
            end
            ST_WR: if (scl_rise) begin
               if (bcnt < 4'd8) begin
                  sh_n   = {sh[6:0], sda_s};
                  bcnt_n = bcnt + 4'd1;
               end else begin
                  bcnt_n            = '0;
                  rx_wr             = 1'b1;
                  flag_set[FL_RXOV] = rx_full & ~rx_pop;
                  flag_set[FL_PAR]  = (sda_s == ^sh);
                  flag_set[FL_WOVF] = (wcnt >= {1'b0, max_wr_len});
                  wcnt_n            = (&wcnt) ? wcnt : wcnt + 1'b1;
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (bcnt < 4'd7) begin
                     bcnt_n = bcnt + 4'd1;
                     o_n    = sh[3'd6 - bcnt[2:0]];
                  end else if (bcnt == 4'd7) begin
                     bcnt_n = 4'd8;
                     more_n = nxt_more;
                     o_n    = nxt_more;
                  end else if (more) begin
                     load = 1'b1;
                  end else begin
                     oe_n = 1'b0;
                     o_n  = 1'b1;
                     st_n = ST_RDEND;
                  end
               end else if (scl_rise && bcnt == 4'd8 && more) begin
                  oe_n = 1'b0;
               end
            end
            default: ;
         endcase
      end
      if (load) begin
         tx_rd             = tx_full;
         flag_set[FL_TXUN] = ~tx_full;
         sh_n              = tx_full ? tx_data : UNDERRUN_BYTE;
         oe_n              = 1'b1;
         o_n               = tx_full ? tx_data[7] : UNDERRUN_BYTE[7];
         bcnt_n            = '0;
         rcnt_n            = (&rcnt) ? rcnt : rcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         bcnt   <= '0;
         sh     <= '0;
         wcnt   <= '0;
         rcnt   <= '0;
         hit    <= 1'b0;
         more   <= 1'b0;
         sda_oe <= 1'b0;
         sda_o  <= 1'b1;
         rnw    <= 1'b0;
      end else begin
         st     <= st_n;
         bcnt   <= bcnt_n;
         sh     <= sh_n;
         wcnt   <= wcnt_n;
         rcnt   <= rcnt_n;
         hit    <= hit_n;
         more   <= more_n;
         sda_oe <= oe_n;
         sda_o  <= o_n;
         rnw    <= rnw_n;
      end
   end

endmodule

// File: rtl/i3c_priv_target.sv
module i3c_priv_target
   import i3ct_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i3c_i,
   input  logic [6:0]        dyn_addr_i,
   input  logic [LEN_W-1:0]  max_wr_len_i,
   input  logic [LEN_W-1:0]  max_rd_len_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              sda_o,
   output logic [7:0]        rx_data_o,
   output logic              rx_full_o,
   input  logic              rx_pop_i,
   input  logic [7:0]        tx_data_i,
   input  logic              tx_push_i,
   output logic              tx_full_o,
   output logic              rnw_o,
   output logic [FLAG_N-1:0] flags_o,
   input  logic [FLAG_N-1:0] flags_clr_i
);

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              rx_wr, tx_rd;
   logic [7:0]        rx_wdat, tx_q;
   logic [FLAG_N-1:0] flag_set;

   i3ct_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i3ct_xfer #(.LEN_W(LEN_W)) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_s      (sda_s),
      .mode_i3c   (mode_i3c_i),
      .dyn_addr   (dyn_addr_i),
      .max_wr_len (max_wr_len_i),
      .max_rd_len (max_rd_len_i),
      .rx_full    (rx_full_o),
      .rx_pop     (rx_pop_i),
      .tx_full    (tx_full_o),
      .tx_data    (tx_q),
      .rx_wr      (rx_wr),
      .rx_wdat    (rx_wdat),
      .tx_rd      (tx_rd),
      .sda_oe     (sda_oe_o),
      .sda_o      (sda_o),
      .rnw        (rnw_o),
      .flag_set   (flag_set)
   );

   i3ct_slot #(.W(8)) u_rx_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (rx_wr),
      .wdat_i (rx_wdat),
      .rd_i   (rx_pop_i),
      .full_o (rx_full_o),
      .data_o (rx_data_o)
   );

   i3ct_slot #(.W(8)) u_tx_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (tx_push_i),
      .wdat_i (tx_data_i),
      .rd_i   (tx_rd),
      .full_o (tx_full_o),
      .data_o (tx_q)
   );

   i3ct_flags #(.N(FLAG_N)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (flag_set),
      .clr_i   (flags_clr_i),
      .flags_o (flags_o)
   );

endmodule

// File: rtl/i3ct_chk.sv
module i3ct_chk #(
   parameter int FLAG_N = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_i3c_i,
   input logic [7:0]        rx_data_o,
   input logic              rx_full_o,
   input logic              rx_pop_i,
   input logic              tx_full_o,
   input logic              tx_push_i,
   input logic [FLAG_N-1:0] flags_o,
   input logic [FLAG_N-1:0] flags_clr_i
);

   AST_MATCH_NEEDS_I3C: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[0]) |-> $past(mode_i3c_i)); // R1

   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full_o && !rx_pop_i) |=> rx_full_o); // R4

   AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full_o && !rx_pop_i) |=> $stable(rx_data_o)); // R11

   AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[3]) |-> (flags_o[1] || flags_o[2])); // R10

   AST_TX_FILL_BY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_full_o) |-> $past(tx_push_i)); // R13

   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_sticky
         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !flags_clr_i[i]) |=> flags_o[i]); // R13
      end
   endgenerate

endmodule

bind i3c_priv_target i3ct_chk #(.FLAG_N(i3ct_pkg::FLAG_N)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i3c_i  (mode_i3c_i),
   .rx_data_o   (rx_data_o),
   .rx_full_o   (rx_full_o),
   .rx_pop_i    (rx_pop_i),
   .tx_full_o   (tx_full_o),
   .tx_push_i   (tx_push_i),
   .flags_o     (flags_o),
   .flags_clr_i (flags_clr_i)
);

// File: tb/test_i3c_priv_target.sv
`timescale 1ns/1ps
module test_i3c_priv_target;

   localparam int LW = 4;
   localparam int Q  = 8;
   localparam logic [6:0] DA = 7'h2A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode = 1'b1;
   logic [LW-1:0] mwl = 4'd15;
   logic [LW-1:0] mrl = 4'd15;
   logic          scl = 1'b1;
   logic          csda = 1'b1;
   logic          sda_oe, sda_o;
   logic [7:0]    rx_data;
   logic          rx_full, rx_pop = 1'b0;
   logic [7:0]    tx_data = 8'h00;
   logic          tx_push = 1'b0, tx_full, rnw;
   logic [7:0]    flags, fclr = 8'h00;
   wire           sda_bus = csda & (sda_oe ? sda_o : 1'b1);

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   i3c_priv_target #(.LEN_W(LW), .SYNC_STAGES(2)) i_i3c_priv_target (
      .clk(clk), .rst_n(rst_n), .mode_i3c_i(mode), .dyn_addr_i(DA),
      .max_wr_len_i(mwl), .max_rd_len_i(mrl), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .sda_o(sda_o), .rx_data_o(rx_data), .rx_full_o(rx_full),
      .rx_pop_i(rx_pop), .tx_data_i(tx_data), .tx_push_i(tx_push), .tx_full_o(tx_full),
      .rnw_o(rnw), .flags_o(flags), .flags_clr_i(fclr));

   // stimulus vectors: {address, data, flip transition bit, expect ack}
   localparam int NV = 5;
   localparam logic [16:0] VEC [NV] = '{
      {7'h2A, 8'hA5, 1'b0, 1'b1},
      {7'h2A, 8'h00, 1'b0, 1'b1},
      {7'h2A, 8'hFF, 1'b0, 1'b1},
      {7'h2A, 8'h3C, 1'b1, 1'b1},
      {7'h15, 8'h77, 1'b0, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clr_all();
      fclr = 8'hFF; tick(1); fclr = 8'h00;
   endtask

   task automatic pop();
      rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
   endtask

   task automatic push(input logic [7:0] v);
      tx_data = v; tx_push = 1'b1; tick(1); tx_push = 1'b0;
   endtask

   task automatic bus_start();
      if (!scl) begin
         csda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      end
      csda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      csda = 1'b0; tick(Q); scl = 1'b1; tick(Q); csda = 1'b1; tick(Q);
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      tick(Q/2); csda = b; tick(Q/2);
      r = sda_bus; scl = 1'b1; tick(Q); scl = 1'b0;
   endtask

   task automatic send_hdr(input logic [6:0] a, input logic rw, output logic ack);
      logic r;
      for (int i = 6; i >= 0; i--) bit_xfer(a[i], r);
      bit_xfer(rw, r);
      bit_xfer(1'b1, r);
      ack = ~r;
   endtask

   task automatic wr_byte(input logic [7:0] d, input logic t);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
      bit_xfer(t, r);
   endtask

   task automatic rd_byte(output logic [7:0] d, output logic t,
                          input logic push_nxt, input logic [7:0] nxt, input logic abort);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         d[i] = r;
         if (i == 4 && push_nxt) push(nxt);
      end
      if (!abort) bit_xfer(1'b1, t);
      else begin
         tick(Q/2); csda = 1'b1; tick(Q/2);
         t = sda_bus; scl = 1'b1; tick(6);
         csda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
   end

   initial begin : main
      logic ack, t;
      logic [7:0] d;
      tick(5);
      rst_n = 1'b1;
      tick(3);

      // reset state (R13)
      chk("R13", "flags after reset", flags, 8'h00);
      chk("R13", "rx_full after reset", rx_full, 0);
      chk("R13", "tx_full after reset", tx_full, 0);
      chk("R2", "sda_oe after reset", sda_oe, 0);

      // table of single-byte writes (R2 R3 R4 R5 R10)
      for (int v = 0; v < NV; v++) begin
         logic [6:0] a;
         logic [7:0] dv;
         logic fl, ea;
         {a, dv, fl, ea} = VEC[v];
         clr_all();
         bus_start();
         send_hdr(a, 1'b0, ack);
         wr_byte(dv, (~^dv) ^ fl);
         bus_stop();
         tick(4);
         chk(ea ? "R2" : "R3", "ack", ack, ea);
         if (ea) begin
            chk("R4", "rx byte", rx_data, dv);
            chk("R4", "rx_full", rx_full, 1);
            chk("R2", "rnw write", rnw, 0);
            chk(fl ? "R5" : "R10", "flags", flags, 8'h0B | (fl ? 8'h10 : 8'h00));
         end else begin
            chk("R3", "rx_full", rx_full, 0);
            chk("R3", "flags", flags, 8'h00);
         end
         if (rx_full) pop();
         tick(2);
      end

      // legacy mode ignores header (R1)
      mode = 1'b0;
      clr_all();
      bus_start();
      send_hdr(DA, 1'b0, ack);
      wr_byte(8'h44, 1'b1);
      bus_stop();
      tick(4);
      chk("R1", "ack in legacy mode", ack, 0);
      chk("R1", "flags in legacy mode", flags, 8'h00);
      chk("R1", "rx_full in legacy mode", rx_full, 0);
      mode = 1'b1;

      // write length limit, then end by repeated start (R6 R10)
      mwl = 4'd2;
      clr_all();
      bus_start();
      send_hdr(DA, 1'b0, ack);
      wr_byte(8'h11, ~^8'h11); pop();
      wr_byte(8'h22, ~^8'h22); pop();
      tick(2);
      chk("R6", "no overflow at limit", flags[5], 0);
      wr_byte(8'h33, ~^8'h33);
      tick(4);
      chk("R6", "overflow past limit", flags[5], 1);
      chk("R6", "byte still delivered", rx_data, 8'h33);
      pop();
      bus_start();
      tick(4);
      chk("R10", "restart ends write", flags[3:1], 3'b110);
      bus_stop();
      tick(4);
      chk("R10", "stop after bare header", flags[1], 0);
      mwl = 4'd15;

      // receive overrun (R11)
      clr_all();
      bus_start();
      send_hdr(DA, 1'b0, ack);
      wr_byte(8'h5E, ~^8'h5E);
      wr_byte(8'h6F, ~^8'h6F);
      bus_stop();
      tick(4);
      chk("R11", "old byte kept", rx_data, 8'h5E);
      chk("R11", "overrun flag", flags[6], 1);
      pop();
      tick(2);
      chk("R13", "pop clears rx_full", rx_full, 0);

      // read two bytes (R7 R8 R2)
      clr_all();
      push(8'hC3);
      chk("R13", "push sets tx_full", tx_full, 1);
      bus_start();
      send_hdr(DA, 1'b1, ack);
      chk("R2", "read ack", ack, 1);
      rd_byte(d, t, 1'b1, 8'h5A, 1'b0);
      chk("R7", "first read byte", d, 8'hC3);
      chk("R7", "T more data", t, 1);
      rd_byte(d, t, 1'b0, 8'h00, 1'b0);
      chk("R7", "second read byte", d, 8'h5A);
      chk("R8", "T end of data", t, 0);
      bus_stop();
      tick(4);
      chk("R10", "read end flags", flags, 8'h0B);
      chk("R2", "rnw read", rnw, 1);
      chk("R13", "tx_full after load", tx_full, 0);

      // transmit underrun (R11)
      clr_all();
      bus_start();
      send_hdr(DA, 1'b1, ack);
      rd_byte(d, t, 1'b0, 8'h00, 1'b0);
      bus_stop();
      tick(4);
      chk("R11", "underrun byte", d, 8'hFF);
      chk("R11", "underrun T", t, 0);
      chk("R11", "underrun flag", flags[7], 1);

      // read length limit (R12)
      mrl = 4'd1;
      clr_all();
      push(8'h11);
      bus_start();
      send_hdr(DA, 1'b1, ack);
      rd_byte(d, t, 1'b1, 8'h22, 1'b0);
      bus_stop();
      tick(4);
      chk("R12", "byte at limit", d, 8'h11);
      chk("R12", "T forced low", t, 0);
      chk("R12", "queued byte kept", tx_full, 1);
      mrl = 4'd15;

      // controller abort on transition bit (R9)
      clr_all();
      bus_start();
      send_hdr(DA, 1'b1, ack);
      rd_byte(d, t, 1'b1, 8'h33, 1'b1);
      tick(4);
      chk("R9", "byte before abort", d, 8'h22);
      chk("R9", "T high before abort", t, 1);
      chk("R9", "abort flags", flags[3:1], 3'b110);
      bus_stop();
      tick(4);
      chk("R9", "no stop flag", flags[1], 0);

      // selective write-one-to-clear (R13)
      fclr = 8'h04; tick(1); fclr = 8'h00;
      tick(2);
      chk("R13", "clear only restart", flags, 8'h09);

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

endmodule